// File: doc/BRIEF.md
# Page Table Address Translator

This block maps a virtual address to a physical address by walking a page table held in ordinary memory. A requester presents a virtual address together with the kind of access (read or write, user or supervisor). The block computes where the matching table entry lives, fetches it through a narrow memory read port, and checks it. It then returns either the physical address or a fault code. The physical address is the entry's frame number placed above the untouched page offset. No adder is involved in that step.

Two table layouts are selected by an input sampled at request acceptance. In flat mode the whole page number indexes one table that starts at the base input. In two-level mode the upper page-number bits index a top table at the base input. A valid top entry names the frame that holds a second table, and the lower page-number bits index that second table. Only one translation is in flight at a time. The block holds no cache of translations.

Top module: `pt_walker`

## Requirements
- R1: In flat mode (`two_level`=0 at acceptance) the block makes exactly one fetch, at address `tbl_base + VA[31:12]*4`. A permitted result has fault code 2'b00 and `rsp_addr = {frame, VA[11:0]}`.
- R2: A table entry is PTE_W bits wide. Bit 0 is valid, bit 1 grants write access, bit 2 grants user-mode access, and bits [PTE_W-1:3] hold the frame number.
- R3: A leaf entry with bit 0 clear gives fault code 2'b01 (page fault), and `rsp_addr` carries the faulting virtual address.
- R4: A write (`req_write`=1) to an entry whose bit 1 is clear, or a user access (`req_user`=1) to an entry whose bit 2 is clear, gives fault code 2'b10 (protection fault) with `rsp_addr` equal to the virtual address. Supervisor reads ignore both rights bits.
- R5: In two-level mode the first fetch is at `tbl_base + VA[31:22]*4`. A valid top entry with frame F leads to a second fetch at `{F,12'h000} + VA[21:12]*4`. The rights and frame of the second entry decide the result.
- R6: In two-level mode an invalid top entry gives a page fault after that single fetch, with no second fetch.
- R7: `req_ready` is low from acceptance until the response handshake completes. While `rsp_ready` is low, `rsp_valid`, `rsp_addr` and `rsp_fault` hold steady.
- R8: `tbl_base` and `two_level` are sampled only at acceptance. Changing them during a walk does not alter the result.
- R9: A fetch request holds `mem_addr` steady until `mem_req_ready`. With memory that is always ready and answers one cycle after acceptance, `rsp_valid` rises 2 clock edges after acceptance per fetch. Each cycle of `mem_req_ready` low adds one edge.
- R10: During and after reset, `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | ADDR_W | Physical address of the flat or top-level table |
| two_level | input | 1 | Selects the two-level walk |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_va | input | ADDR_W | Virtual address to translate |
| req_write | input | 1 | Access is a store |
| req_user | input | 1 | Access comes from user mode |
| mem_req_valid | output | 1 | Entry fetch request |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_addr | output | ADDR_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Fetched entry present |
| mem_rsp_data | input | PTE_W | Fetched entry |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_addr | output | ADDR_W | Physical address, or the virtual address on a fault |
| rsp_fault | output | 2 | 00 none, 01 page fault, 10 protection fault |

## Verification
Every result is due a fixed number of edges after the acceptance edge. The count is two edges per entry fetched when memory is ready at once, and one more edge for each stalled cycle of `mem_req_ready`. The bench counts the edges from acceptance and samples outputs only at the following falling edge. It compares that count against two times the expected number of fetches, plus any stall it injected. The memory model logs every fetch address. The first-fetch address and the number of fetches per walk are therefore checked alongside the result, so a walk that fetched the wrong entry or one too many cannot pass on its final value alone.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int TOP_W  = 10,
  parameter int ENT_SH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            tbl_base,
  input  logic                         two_level,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [ADDR_W-1:0]            req_va,
  input  logic                         req_write,
  input  logic                         req_user,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic [ADDR_W-1:0]            mem_addr,
  input  logic                         mem_rsp_valid,
  input  logic [ADDR_W-OFF_W+2:0]      mem_rsp_data,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [ADDR_W-1:0]            rsp_addr,
  output logic [1:0]                   rsp_fault
);
  localparam int VPN_W = ADDR_W - OFF_W;
  localparam int LOW_W = VPN_W - TOP_W;
  localparam int PPN_W = ADDR_W - OFF_W;

  localparam logic [1:0] F_NONE = 2'b00;
  localparam logic [1:0] F_PAGE = 2'b01;
  localparam logic [1:0] F_PROT = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_RESP} state_t;

  state_t            state;
  logic [ADDR_W-1:0] va_q, addr_q, res_q;
  logic              wr_q, usr_q, leaf_q;
  logic [1:0]        fault_q;

  logic [VPN_W-1:0]  req_vpn;
  logic [TOP_W-1:0]  req_top;
  logic [LOW_W-1:0]  va_low;
  logic              pte_v, pte_w, pte_u, denied;
  logic [PPN_W-1:0]  pte_ppn;
  logic [ADDR_W-1:0] first_addr, second_addr;

  assign req_vpn = req_va[ADDR_W-1:OFF_W];
  assign req_top = req_va[ADDR_W-1 -: TOP_W];
  assign va_low  = va_q[OFF_W +: LOW_W];

  assign pte_v   = mem_rsp_data[0];
  assign pte_w   = mem_rsp_data[1];
  assign pte_u   = mem_rsp_data[2];
  assign pte_ppn = mem_rsp_data[PPN_W+2:3];
  assign denied  = (wr_q && !pte_w) || (usr_q && !pte_u);

  assign first_addr  = tbl_base + (two_level ? (ADDR_W'(req_top) << ENT_SH)
                                             : (ADDR_W'(req_vpn) << ENT_SH));
  assign second_addr = {pte_ppn, {OFF_W{1'b0}}} + (ADDR_W'(va_low) << ENT_SH);

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_FETCH);
  assign mem_addr      = addr_q;
  assign rsp_valid     = (state == S_RESP);
  assign rsp_addr      = res_q;
  assign rsp_fault     = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      res_q   <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      leaf_q  <= 1'b0;
      fault_q <= F_NONE;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q   <= req_va;
          wr_q   <= req_write;
          usr_q  <= req_user;
          leaf_q <= !two_level;
          addr_q <= first_addr;
          state  <= S_FETCH;
        end
        S_FETCH: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!pte_v) begin
            fault_q <= F_PAGE;
            res_q   <= va_q;
            state   <= S_RESP;
          end else if (!leaf_q) begin
            addr_q <= second_addr;
            leaf_q <= 1'b1;
            state  <= S_FETCH;
          end else if (denied) begin
            fault_q <= F_PROT;
            res_q   <= va_q;
            state   <= S_RESP;
          end else begin
            fault_q <= F_NONE;
            res_q   <= {pte_ppn, va_q[OFF_W-1:0]};
            state   <= S_RESP;
          end
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_va,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [1:0]        rsp_fault
);
  logic [ADDR_W-1:0] va_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) va_seen <= '0;
    else if (req_valid && req_ready) va_seen <= req_va;
  end

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !rsp_valid));

  p_busy_until_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_rsp_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)));

  p_fetch_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

  p_fetch_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_addr[1:0] == 2'b00));

  p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'b00) |-> (rsp_addr[OFF_W-1:0] == va_seen[OFF_W-1:0]));

  p_fault_gives_va_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> (rsp_addr == va_seen));

  p_fault_code_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault != 2'b11));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_addr(mem_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tbl_base = '0;
  logic        two_level = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready;
  logic        mem_req_valid, mem_req_ready = 1'b1;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [22:0] mem_rsp_data = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [31:0] rsp_addr;
  logic [1:0]  rsp_fault;

  always #10 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .two_level(two_level),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_user(req_user),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
  );

  logic [22:0] mem [4096];
  logic [31:0] addr_log [64];
  int          fetch_cnt = 0;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem[mem_addr[13:2]];
      addr_log[fetch_cnt % 64] <= mem_addr;
      fetch_cnt <= fetch_cnt + 1;
    end
  end

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      report();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  logic [31:0] o_addr, o_first;
  logic [1:0]  o_fault;
  int          o_lat, o_nf;

  task automatic walk(input bit mode, input logic [31:0] va, input bit wr, input bit usr,
                      input int stall, input bit disturb, input int hold);
    int f0;
    @(negedge clk);
    tbl_base  = mode ? 32'h2000 : 32'h0;
    two_level = mode;
    req_va = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    f0 = fetch_cnt;
    @(posedge clk);
    o_lat = 0;
    @(negedge clk);
    req_valid = 1'b0;
    if (stall > 0) mem_req_ready = 1'b0;
    if (disturb) begin tbl_base = 32'h2000; two_level = ~mode; end
    while (!rsp_valid && o_lat < 40) begin
      @(posedge clk);
      o_lat++;
      @(negedge clk);
      if (o_lat == stall) mem_req_ready = 1'b1;
    end
    o_addr = rsp_addr; o_fault = rsp_fault;
    o_nf = fetch_cnt - f0;
    o_first = addr_log[f0 % 64];
    if (hold > 0) begin
      repeat (hold) @(posedge clk);
      @(negedge clk);
      chk("R7 valid held", {31'b0, rsp_valid}, 32'd1);
      chk("R7 ready low while held", {31'b0, req_ready}, 32'd0);
      chk("R7 addr held", rsp_addr, o_addr);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R7 ready after handshake", {31'b0, req_ready}, 32'd1);
  endtask

  // mode, write, user, fault, va, expected addr, fetches
  localparam int NV = 12;
  localparam logic [70:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 2'b00, 32'h0000_5ABC, 32'h1234_5ABC, 2'd1},
    {1'b0, 1'b1, 1'b1, 2'b00, 32'h0000_5FFF, 32'h1234_5FFF, 2'd1},
    {1'b0, 1'b0, 1'b0, 2'b00, 32'h0000_6010, 32'hABCD_E010, 2'd1},
    {1'b0, 1'b1, 1'b0, 2'b10, 32'h0000_6010, 32'h0000_6010, 2'd1},
    {1'b0, 1'b0, 1'b1, 2'b10, 32'h0000_6010, 32'h0000_6010, 2'd1},
    {1'b0, 1'b0, 1'b0, 2'b01, 32'h0000_7000, 32'h0000_7000, 2'd1},
    {1'b0, 1'b1, 1'b1, 2'b10, 32'h0000_8123, 32'h0000_8123, 2'd1},
    {1'b0, 1'b0, 1'b1, 2'b00, 32'h0000_8123, 32'h0004_2123, 2'd1},
    {1'b1, 1'b0, 1'b1, 2'b00, 32'h0040_3456, 32'h0BEE_F456, 2'd2},
    {1'b1, 1'b1, 1'b0, 2'b01, 32'h0080_0000, 32'h0080_0000, 2'd1},
    {1'b1, 1'b0, 1'b0, 2'b01, 32'h0040_4000, 32'h0040_4000, 2'd2},
    {1'b0, 1'b1, 1'b0, 2'b00, 32'h0000_5000, 32'h1234_5000, 2'd1}
  };

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    // entry = {frame, user, write, valid}  (R2)
    mem[12'h005] = {20'h12345, 3'b111};
    mem[12'h006] = {20'hABCDE, 3'b001};
    mem[12'h008] = {20'h00042, 3'b101};
    mem[12'h801] = {20'h00003, 3'b001};
    mem[12'hC03] = {20'h0BEEF, 3'b111};

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset req_ready", {31'b0, req_ready}, 32'd1);
    chk("R10 reset mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
    chk("R10 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset", {31'b0, req_ready}, 32'd1);

    for (int v = 0; v < NV; v++) begin
      logic [70:0] e;
      logic [31:0] exp_first;
      e = VEC[v];
      exp_first = e[70] ? (32'h2000 + {20'b0, e[65:56], 2'b00})
                        : {10'b0, e[65:46], 2'b00};
      walk(e[70], e[65:34], e[69], e[68], 0, 1'b0, 0);
      chk($sformatf("R1 R5 vec%0d addr", v), o_addr, e[33:2]);
      chk($sformatf("R3 R4 vec%0d fault", v), {30'b0, o_fault}, {30'b0, e[67:66]});
      chk($sformatf("R5 R6 vec%0d fetches", v), o_nf, {30'b0, e[1:0]});
      chk($sformatf("R1 R5 vec%0d first fetch", v), o_first, exp_first);
      chk($sformatf("R9 vec%0d latency", v), o_lat, 2 * int'(e[1:0]));
    end

    walk(1'b1, 32'h0040_3456, 1'b0, 1'b0, 0, 1'b0, 0);
    chk("R5 second fetch address", addr_log[(fetch_cnt - 1) % 64], 32'h0000_300C);

    walk(1'b0, 32'h0000_5ABC, 1'b0, 1'b1, 0, 1'b1, 0);
    chk("R8 config change ignored addr", o_addr, 32'h1234_5ABC);
    chk("R8 config change ignored fetches", o_nf, 32'd1);

    walk(1'b0, 32'h0000_6777, 1'b0, 1'b0, 3, 1'b0, 0);
    chk("R9 stalled fetch latency", o_lat, 32'd5);
    chk("R9 stalled fetch addr", o_addr, 32'hABCD_E777);

    walk(1'b0, 32'h0000_5123, 1'b1, 1'b1, 0, 1'b0, 4);
    chk("R7 held result addr", o_addr, 32'h1234_5123);

    report();
    $finish;
  end
endmodule